// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block decides whether a program or erase request aimed at one bank of a flash array may go ahead. The bank is carved into large main blocks of 32 KWord at its low end and small parameter blocks of 4 KWord at its top (a top-boot arrangement). Each block keeps two state bits: a lock bit and a lock-down bit. Commands already decoded upstream set or clear these bits for the block that holds the command address. A write-protect pin is combined with the two bits of the targeted block to grant or refuse each request.

Every request gets a one-cycle answer in the cycle after it is presented: either a grant pulse or a deny strobe. A separate combinational readback port returns the two state bits of any block, so the protection status can be shown on the device's identification read path. The lock state is never changed by a refused request. Reset is asynchronous on assertion and leaves every block locked. Release is synchronised inside the block and takes two clock edges.

Top module: `blk_wprot_ctrl`

## Requirements
- R1: After reset, every block reads back lock=1 and lockdown=0, and neither req_grant nor req_deny is high.
- R2: With default parameters, word address A in 1F8000h..1FFFFFh selects block 14 + (A-1F8000h)/1000h. A in 188000h..1F7FFFh selects block (A-188000h)/8000h. Below 188000h no block is selected and stat_hit is 0.
- R3: A request to a block is allowed only if its lock bit is 0 and either its lockdown bit is 0 or wp_pin is 1. Every other combination of {wp_pin, lockdown, lock} is refused, including {0,1,0}.
- R4: In the cycle after req_valid, exactly one of req_grant and req_deny is high, for one cycle only. A request outside the bank is denied, and a denied request leaves every block's state unchanged.
- R5: cmd_op encodes 01=lock, 10=unlock, 11=lock-down, 00=no operation. Lock sets the lock bit. Lock-down sets both bits. Unlock clears the lock bit unless lockdown=1 and wp_pin=0. Only the addressed block changes, and a command outside the bank changes nothing.
- R6: A set lockdown bit is cleared only by reset, never by a command.
- R7: Any combination of blocks may be locked or unlocked independently of the others.
- R8: A request and a command in the same cycle: the request is judged on the state held before that command. The command's effect shows from the next cycle on.
- R9: stat_lock and stat_down return, without a clock delay, the bits of the block selected by stat_addr. They return 0 when stat_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Write-protect pin, 1 overrides lock-down |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | Command code (R5) |
| cmd_addr | input | 21 | Word address selecting the command's block |
| req_valid | input | 1 | Program/erase permission request |
| req_addr | input | 21 | Word address of the request |
| req_grant | output | 1 | One-cycle grant pulse |
| req_deny | output | 1 | One-cycle deny/error strobe |
| stat_addr | input | 21 | Word address for status readback |
| stat_hit | output | 1 | stat_addr lies in the bank |
| stat_lock | output | 1 | Lock bit of the selected block |
| stat_down | output | 1 | Lockdown bit of the selected block |

## Verification
The two functions that can fall in the same cycle are a permission request and a command that changes the same block. The bench drives an unlock and a request at one locked block in a single cycle and expects a deny. It then expects the readback to show the block as unlocked and a second request to be granted. It also pairs a lock with a request at an unlocked block and expects a grant, because the request is judged on the state before the command.

// File: rtl/blk_wprot_pkg.sv
package blk_wprot_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_DOWN   = 2'b11
  } prot_op_e;

endpackage

// File: rtl/blk_addr_dec.sv
module blk_addr_dec #(
  parameter int ADDR_W    = 21,
  parameter int PARAM_W   = 12,
  parameter int MAIN_W    = 15,
  parameter int NUM_PARAM = 8,
  parameter int NUM_MAIN  = 14,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam longint TOP        = longint'(1) << ADDR_W;
  localparam longint PARAM_BASE = TOP - (longint'(NUM_PARAM) << PARAM_W);
  localparam longint MAIN_BASE  = PARAM_BASE - (longint'(NUM_MAIN) << MAIN_W);

  logic [ADDR_W-1:0] p_off;
  logic [ADDR_W-1:0] m_off;
  logic              in_param;

  always_comb begin
    p_off    = addr - ADDR_W'(PARAM_BASE);
    m_off    = addr - ADDR_W'(MAIN_BASE);
    in_param = ({1'b0, addr} >= (ADDR_W+1)'(PARAM_BASE));
    hit      = ({1'b0, addr} >= (ADDR_W+1)'(MAIN_BASE));
    if (!hit)
      idx = '0;
    else if (in_param)
      idx = IDX_W'(NUM_MAIN) + IDX_W'(p_off >> PARAM_W);
    else
      idx = IDX_W'(m_off >> MAIN_W);
  end
endmodule

// File: rtl/blk_perm_eval.sv
module blk_perm_eval (
  input  logic wp,
  input  logic down,
  input  logic lock,
  output logic allow
);
  always_comb begin
    case ({wp, down, lock})
      3'b100, 3'b110, 3'b000: allow = 1'b1;
      default:                allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/blk_lock_array.sv
module blk_lock_array
  import blk_wprot_pkg::*;
#(
  parameter int NUM_BLK = 22,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp,
  input  logic               cmd_valid,
  input  prot_op_e           cmd_op,
  input  logic               cmd_hit,
  input  logic [IDX_W-1:0]   cmd_idx,
  output logic [NUM_BLK-1:0] lk_q,
  output logic [NUM_BLK-1:0] dn_q
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic sel;
    logic lk_d;
    logic dn_d;

    always_comb begin
      sel  = cmd_valid && cmd_hit && (cmd_idx == IDX_W'(g));
      lk_d = lk_q[g];
      dn_d = dn_q[g];
      if (sel) begin
        case (cmd_op)
          OP_LOCK:   lk_d = 1'b1;
          OP_UNLOCK: if (!(dn_q[g] && !wp)) lk_d = 1'b0;
          OP_DOWN: begin
            lk_d = 1'b1;
            dn_d = 1'b1;
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q[g] <= 1'b1;
        dn_q[g] <= 1'b0;
      end else if (sel) begin
        lk_q[g] <= lk_d;
        dn_q[g] <= dn_d;
      end
    end
  end

  // R6: lockdown bits never fall outside reset
  a_r6_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dn_q) & ~dn_q) == '0));

  // R5: at most one block changes per cycle, and only after a command
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((lk_q ^ $past(lk_q)) | (dn_q ^ $past(dn_q))) <= 1);

  a_r5_change_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_q != $past(lk_q)) || (dn_q != $past(dn_q))) |-> $past(cmd_valid));
endmodule

// File: rtl/blk_wprot_ctrl.sv
module blk_wprot_ctrl
  import blk_wprot_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PARAM_W   = 12,
  parameter int MAIN_W    = 15,
  parameter int NUM_PARAM = 8,
  parameter int NUM_MAIN  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_grant,
  output logic              req_deny,
  input  logic [ADDR_W-1:0] stat_addr,
  output logic              stat_hit,
  output logic              stat_lock,
  output logic              stat_down
);
  localparam int NUM_BLK = NUM_PARAM + NUM_MAIN;
  localparam int IDX_W   = $clog2(NUM_BLK);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             c_hit, r_hit;
  logic [IDX_W-1:0] c_idx, r_idx, s_idx;

  blk_addr_dec #(.ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
                 .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN), .IDX_W(IDX_W))
    u_dec_cmd (.addr(cmd_addr), .hit(c_hit), .idx(c_idx));

  blk_addr_dec #(.ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
                 .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN), .IDX_W(IDX_W))
    u_dec_req (.addr(req_addr), .hit(r_hit), .idx(r_idx));

  blk_addr_dec #(.ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
                 .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN), .IDX_W(IDX_W))
    u_dec_stat (.addr(stat_addr), .hit(stat_hit), .idx(s_idx));

  logic [NUM_BLK-1:0] lk_vec, dn_vec;

  blk_lock_array #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_locks (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wp        (wp_pin),
    .cmd_valid (cmd_valid),
    .cmd_op    (prot_op_e'(cmd_op)),
    .cmd_hit   (c_hit),
    .cmd_idx   (c_idx),
    .lk_q      (lk_vec),
    .dn_q      (dn_vec)
  );

  logic r_lock, r_down, r_allow;

  always_comb begin
    r_lock    = r_hit ? lk_vec[r_idx] : 1'b1;
    r_down    = r_hit ? dn_vec[r_idx] : 1'b0;
    stat_lock = stat_hit ? lk_vec[s_idx] : 1'b0;
    stat_down = stat_hit ? dn_vec[s_idx] : 1'b0;
  end

  blk_perm_eval u_perm (
    .wp    (wp_pin),
    .down  (r_down),
    .lock  (r_lock),
    .allow (r_allow)
  );

  logic grant_d, deny_d;

  always_comb begin
    grant_d = req_valid && r_hit && r_allow;
    deny_d  = req_valid && !(r_hit && r_allow);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_grant <= 1'b0;
      req_deny  <= 1'b0;
    end else begin
      req_grant <= grant_d;
      req_deny  <= deny_d;
    end
  end

  // R4: one outcome per request, no strobe without a request
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> (req_grant != req_deny));

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_grant || req_deny) |-> $past(req_valid));

  // R3: a locked-down block with the pin low is always refused
  a_r3_down_pin_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && r_hit && !wp_pin && dn_vec[r_idx]) |=> req_deny);

  // R3: a locked block is never granted
  a_r3_locked_refused: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && r_hit && lk_vec[r_idx]) |=> !req_grant);
endmodule

// File: tb/blk_wprot_ctrl_bench.sv
module blk_wprot_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_pin = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [20:0] cmd_addr = '0;
  logic        req_valid = 1'b0;
  logic [20:0] req_addr = '0;
  logic [20:0] stat_addr = '0;
  logic        req_grant, req_deny, stat_hit, stat_lock, stat_down;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit exp_lk [NB];
  bit exp_dn [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_wprot_ctrl u_blk_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_grant(req_grant), .req_deny(req_deny),
    .stat_addr(stat_addr), .stat_hit(stat_hit),
    .stat_lock(stat_lock), .stat_down(stat_down)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int blk_of(logic [20:0] a);
    if (a >= 21'h1F8000) return 14 + int'((a - 21'h1F8000) >> 12);
    if (a >= 21'h188000) return int'((a - 21'h188000) >> 15);
    return -1;
  endfunction

  function automatic logic [20:0] base_of(int i);
    if (i >= 14) return 21'h1F8000 + 21'((i - 14) * 'h1000);
    return 21'h188000 + 21'(i * 'h8000);
  endfunction

  function automatic bit allowed(int i);
    if (i < 0) return 1'b0;
    return !exp_lk[i] && (!exp_dn[i] || wp_pin);
  endfunction

  task automatic model_cmd(logic [1:0] op, logic [20:0] a);
    int i = blk_of(a);
    if (i < 0) return;
    case (op)
      2'b01: exp_lk[i] = 1'b1;
      2'b10: if (!(exp_dn[i] && !wp_pin)) exp_lk[i] = 1'b0;
      2'b11: begin exp_lk[i] = 1'b1; exp_dn[i] = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NB; i++) begin exp_lk[i] = 1'b1; exp_dn[i] = 1'b0; end
  endtask

  task automatic issue_cmd(logic [1:0] op, logic [20:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    model_cmd(op, a);
  endtask

  task automatic issue_req(logic [20:0] a, string tag);
    bit ok = allowed(blk_of(a));
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " grant"}, req_grant, ok);
    chk({tag, " deny"},  req_deny,  !ok);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NB; i++) begin
      stat_addr = base_of(i) + 21'h7;
      #1;
      chk({tag, " hit"},  stat_hit,  1);
      chk({tag, " lock"}, stat_lock, exp_lk[i]);
      chk({tag, " down"}, stat_down, exp_dn[i]);
    end
  endtask

  // R1, R9: reset state
  task automatic t_reset();
    apply_reset();
    chk("R1 grant idle", req_grant, 0);
    chk("R1 deny idle", req_deny, 0);
    check_all("R1 R9 reset status");
  endtask

  // R4, R3: locked block refused, strobe lasts one cycle, state kept
  task automatic t_locked_deny();
    issue_req(base_of(5), "R4 locked block");
    @(negedge clk);
    chk("R4 deny one cycle", req_deny, 0);
    check_all("R4 state after deny");
  endtask

  // R2: address decode across both block sizes and the bank edge
  task automatic t_decode();
    issue_cmd(2'b10, 21'h1FFABC);
    stat_addr = 21'h1FF000; #1;
    chk("R2 block 21 unlocked", stat_lock, 0);
    stat_addr = 21'h1FEFFF; #1;
    chk("R2 block 20 still locked", stat_lock, 1);
    issue_req(21'h1FFFFF, "R2 top word");
    issue_cmd(2'b10, 21'h18FFFF);
    issue_req(21'h188000, "R2 main 0 base");
    issue_req(21'h190000, "R2 main 1 base");
    issue_cmd(2'b10, 21'h1F8000);
    issue_req(21'h1F8FFF, "R2 param 14 end");
    issue_req(21'h1F7FFF, "R2 main 13 end");
    stat_addr = 21'h187FFF; #1;
    chk("R2 below bank hit", stat_hit, 0);
    chk("R9 below bank lock", stat_lock, 0);
    issue_req(21'h187FFF, "R4 outside bank");
  endtask

  // R7: an arbitrary pattern across blocks
  task automatic t_pattern();
    for (int i = 0; i < NB; i++)
      issue_cmd((i % 3 == 0) ? 2'b10 : 2'b01, base_of(i) + 21'h10);
    check_all("R7 pattern");
    issue_req(base_of(3), "R7 unlocked member");
    issue_req(base_of(4), "R7 locked member");
  endtask

  // R3, R5, R6: lock-down against the pin
  task automatic t_lockdown();
    wp_pin = 1'b1;
    issue_cmd(2'b11, base_of(10));
    issue_req(base_of(10), "R3 state 111");
    issue_cmd(2'b10, base_of(10));
    stat_addr = base_of(10); #1;
    chk("R5 unlock with pin high", stat_lock, 0);
    issue_req(base_of(10), "R3 state 110");
    wp_pin = 1'b0;
    issue_req(base_of(10), "R3 state 010");
    issue_cmd(2'b01, base_of(10));
    issue_cmd(2'b10, base_of(10));
    stat_addr = base_of(10); #1;
    chk("R5 unlock refused 011", stat_lock, 1);
    chk("R6 down kept", stat_down, 1);
    issue_req(base_of(10), "R3 state 011");
    issue_cmd(2'b00, base_of(9));
    issue_cmd(2'b10, 21'h000000);
    check_all("R5 nop and outside ignored");
  endtask

  // R8: request and command on one block in the same cycle
  task automatic t_same_cycle();
    bit ok;
    wp_pin = 1'b0;
    issue_cmd(2'b01, base_of(17));
    ok = allowed(17);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = base_of(17);
    req_valid = 1'b1; req_addr = base_of(17);
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    model_cmd(2'b10, base_of(17));
    chk("R8 judged on old lock", req_grant, ok);
    stat_addr = base_of(17); #1;
    chk("R8 unlock visible", stat_lock, 0);
    issue_req(base_of(17), "R8 next request");
    ok = allowed(17);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = base_of(17);
    req_valid = 1'b1; req_addr = base_of(17);
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    model_cmd(2'b01, base_of(17));
    chk("R8 granted before lock", req_grant, ok);
    issue_req(base_of(17), "R8 locked after");
  endtask

  // R6, R1: only reset clears lock-down
  task automatic t_reset_clears();
    apply_reset();
    check_all("R6 R1 after second reset");
  endtask

  initial begin
    t_reset();
    t_locked_deny();
    t_decode();
    t_pattern();
    t_lockdown();
    t_same_cycle();
    t_reset_clears();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule